// File: doc/BRIEF.md
# Stacked-Carrier Nine-Level PWM Modulator

This block turns a signed reference sample into switching commands for one phase of a nine-level cascaded full-bridge inverter. The reference is compared against eight triangular carriers. Each carrier occupies its own amplitude band, and together the bands tile the whole signed range of the reference. Four bands lie below zero and four above. All eight carriers share one frequency and one peak-to-peak swing. A two-bit mode input picks how their phases relate: all together, all inverted, opposed across zero, or alternating band by band.

The comparator results are registered. From them the block derives a signed phase level from -4 to +4 and the four switch commands for each of the four bridge cells. A divider input sets how many clocks each carrier step lasts, which sets the carrier frequency. A package holds divider values for a 50 Hz fundamental with 2 kHz and 10 kHz carriers. A new mode request waits for the end of the current carrier period, so a period never mixes two arrangements.

Top module: `mlpwm_modulator`

## Requirements
- R1: With the default 10-bit reference, the band height is H = 128 and band i (0 = lowest) spans -512 + 128*i to -384 + 128*i. A shared phase count starts at 0 after reset and rises one unit per step up to H. It then falls one unit per step back to 0, and repeats, so a period is 2H steps. A step occurs every max(divSet,1) clocks.
- R2: Comparator bit i is 1 only when the reference is strictly greater than carrier i. The reference sampled at a clock edge is compared with the carriers held before that edge, and the result appears on cmpBits after that edge. A reference equal to -512 clears every bit.
- R3: An in-phase band's carrier is its lower edge plus the phase count. An inverted band's carrier is its upper edge minus the count. The mode code sets which bands are inverted: 0 inverts none, 1 inverts all, 2 inverts bands 0 to 3, and 3 inverts the odd bands.
- R4: The mode in force is PD (code 0) after reset. A requested code takes effect only at the step that brings the falling phase count from 1 to 0. It is sampled at that edge, including when the request changes in that same cycle.
- R5: level equals the number of set comparator bits minus 4, as a 4-bit two's-complement value.
- R6: Cell k (k = 0..3) drives +1 when bit 4+k is set, drives -1 when bit 3-k is clear, and drives 0 otherwise. Its nibble at cellSw[4k+3:4k] uses bit 0 for left-high, bit 1 for left-low, bit 2 for right-high and bit 3 for right-low. The codes are 4'b1001 for +1, 4'b0110 for -1 and 4'b1010 for 0.
- R7: While reset is held, cmpBits is 8'h0F, level is 0 and cellSw is 16'hAAAA, which puts every cell in the zero state.
- R8: The comparator bits always form a run of ones that starts at bit 0, with no gaps.
- R9: With a 100 MHz clock, the package divider values are 195 for a 2 kHz carrier and 39 for a 10 kHz carrier. The frequency ratios to 50 Hz are 40 and 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divSet | input | 16 | Clocks per carrier step |
| modeSel | input | 2 | Requested carrier arrangement code |
| refIn | input | 10 | Signed reference sample |
| cmpBits | output | 8 | Registered comparator results, bit 0 is the lowest band |
| level | output | 4 | Signed phase level, -4 to +4 |
| cellSw | output | 16 | Switch commands, one nibble per cell |

## Verification
A mode request and a carrier period end can fall in the same cycle. The bench provokes this by tracking its own model of the phase count and changing modeSel on the exact cycle before the edge that returns the count to zero. It then judges every following cycle's comparator bits against the new arrangement. It also changes the request mid-period and checks that the old arrangement persists until the boundary. The divider is set to 1 and to 3, so that period ends and direction reversals land both on consecutive clocks and inside longer steps.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int DEF_REF_W = 10;
  localparam int DEF_DIV_W = 16;
  localparam int DEF_CELLS = 4;

  // Frequency settings for a 100 MHz clock and the default band height
  localparam int CLK_HZ = 100_000_000;
  localparam int FUND_HZ = 50;
  localparam int CAR_SLOW_HZ = 2_000;
  localparam int CAR_FAST_HZ = 10_000;
  localparam int DEF_BAND = 2 ** (DEF_REF_W - 3);
  localparam int DIV_SLOW = CLK_HZ / (CAR_SLOW_HZ * 2 * DEF_BAND);
  localparam int DIV_FAST = CLK_HZ / (CAR_FAST_HZ * 2 * DEF_BAND);
  localparam int RATIO_SLOW = CAR_SLOW_HZ / FUND_HZ;
  localparam int RATIO_FAST = CAR_FAST_HZ / FUND_HZ;

  typedef enum logic [1:0] {
    MODE_PD   = 2'd0,
    MODE_IPD  = 2'd1,
    MODE_POD  = 2'd2,
    MODE_APOD = 2'd3
  } carMode_e;

  typedef struct packed {
    logic step;
    logic countUp;
    logic periodEnd;
  } ctrlStrobe_t;

  // switch nibble: bit0 left-high, bit1 left-low, bit2 right-high, bit3 right-low
  localparam logic [3:0] SW_POS  = 4'b1001;
  localparam logic [3:0] SW_NEG  = 4'b0110;
  localparam logic [3:0] SW_ZERO = 4'b1010;

  function automatic logic bandInverted(carMode_e m, int band, int cells);
    case (m)
      MODE_PD:  return 1'b0;
      MODE_IPD: return 1'b1;
      MODE_POD: return band < cells;
      default:  return (band % 2) == 1;
    endcase
  endfunction
endpackage

// File: rtl/mlpwm_ctrl.sv
module mlpwm_ctrl
  import mlpwm_pkg::*;
#(
  parameter int DIV_W = DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSet,
  input  carMode_e         modeReq,
  input  logic             triNearTop,
  input  logic             triNearBottom,
  output ctrlStrobe_t      strobe,
  output carMode_e         activeMode
);
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W:0]   preNext;
  logic             stepNow;
  logic             dirUp;

  assign preNext = {1'b0, preCnt} + {{DIV_W{1'b0}}, 1'b1};
  assign stepNow = preNext >= {1'b0, divSet};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stepNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preNext[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (stepNow) begin
      if (dirUp && triNearTop) begin
        dirUp <= 1'b0;
      end else if (!dirUp && triNearBottom) begin
        dirUp <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode <= MODE_PD;
    end else if (strobe.periodEnd) begin
      activeMode <= modeReq;
    end
  end

  always_comb begin
    strobe.step      = stepNow;
    strobe.countUp   = dirUp;
    strobe.periodEnd = stepNow && !dirUp && triNearBottom;
  end
endmodule

// File: rtl/mlpwm_datapath.sv
module mlpwm_datapath
  import mlpwm_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int NUM_CELLS = DEF_CELLS,
  parameter int LVL_W     = $clog2(NUM_CELLS + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  carMode_e                   activeMode,
  input  logic signed [REF_W-1:0]    refIn,
  output logic                       triNearTop,
  output logic                       triNearBottom,
  output logic [2*NUM_CELLS-1:0]     cmpBits,
  output logic signed [LVL_W-1:0]    level,
  output logic [4*NUM_CELLS-1:0]     cellSw
);
  localparam int NUM_CAR = 2 * NUM_CELLS;
  localparam int BAND_W  = REF_W - $clog2(NUM_CAR);
  localparam int BAND    = 2 ** BAND_W;
  localparam int CAR_W   = REF_W + 1;
  localparam logic [BAND_W:0] BAND_TOP = (BAND_W + 1)'(BAND);

  logic [BAND_W:0]          triCnt;
  logic signed [CAR_W-1:0]  refExt;
  logic [NUM_CAR-1:0]       cmpNext;
  logic signed [LVL_W-1:0]  lvlAcc;

  assign refExt        = {refIn[REF_W-1], refIn};
  assign triNearTop    = triCnt == BAND_TOP - 1'b1;
  assign triNearBottom = triCnt == (BAND_W + 1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triCnt <= '0;
    end else if (strobe.step) begin
      triCnt <= strobe.countUp ? triCnt + 1'b1 : triCnt - 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CAR; i++) begin : g_band
    localparam logic signed [CAR_W-1:0] BASE = CAR_W'(-(2 ** (REF_W - 1)) + i * BAND);
    logic [BAND_W:0]         phaseVal;
    logic signed [CAR_W-1:0] carVal;
    assign phaseVal   = bandInverted(activeMode, i, NUM_CELLS) ? BAND_TOP - triCnt : triCnt;
    assign carVal     = BASE + $signed({{(CAR_W - BAND_W - 1){1'b0}}, phaseVal});
    assign cmpNext[i] = refExt > carVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBits <= {{NUM_CELLS{1'b0}}, {NUM_CELLS{1'b1}}};
    end else begin
      cmpBits <= cmpNext;
    end
  end

  always_comb begin
    lvlAcc = -LVL_W'(NUM_CELLS);
    for (int b = 0; b < NUM_CAR; b++) begin
      if (cmpBits[b]) lvlAcc = lvlAcc + LVL_W'(1);
    end
  end
  assign level = lvlAcc;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    logic upHit, loMiss;
    assign upHit  = cmpBits[NUM_CELLS + k];
    assign loMiss = !cmpBits[NUM_CELLS - 1 - k];
    assign cellSw[4*k +: 4] = upHit ? SW_POS : (loMiss ? SW_NEG : SW_ZERO);
  end
endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator
  import mlpwm_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int DIV_W     = DEF_DIV_W,
  parameter int NUM_CELLS = DEF_CELLS,
  parameter int LVL_W     = $clog2(NUM_CELLS + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DIV_W-1:0]         divSet,
  input  logic [1:0]               modeSel,
  input  logic signed [REF_W-1:0]  refIn,
  output logic [2*NUM_CELLS-1:0]   cmpBits,
  output logic signed [LVL_W-1:0]  level,
  output logic [4*NUM_CELLS-1:0]   cellSw
);
  ctrlStrobe_t strobe;
  carMode_e    activeMode;
  logic        triNearTop;
  logic        triNearBottom;

  mlpwm_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .divSet       (divSet),
    .modeReq      (carMode_e'(modeSel)),
    .triNearTop   (triNearTop),
    .triNearBottom(triNearBottom),
    .strobe       (strobe),
    .activeMode   (activeMode)
  );

  mlpwm_datapath #(.REF_W(REF_W), .NUM_CELLS(NUM_CELLS), .LVL_W(LVL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .activeMode   (activeMode),
    .refIn        (refIn),
    .triNearTop   (triNearTop),
    .triNearBottom(triNearBottom),
    .cmpBits      (cmpBits),
    .level        (level),
    .cellSw       (cellSw)
  );
endmodule

// File: rtl/mlpwm_checker.sv
module mlpwm_checker
  import mlpwm_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int NUM_CELLS = DEF_CELLS,
  parameter int LVL_W     = $clog2(NUM_CELLS + 1) + 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic signed [REF_W-1:0]  refIn,
  input logic [2*NUM_CELLS-1:0]   cmpBits,
  input logic signed [LVL_W-1:0]  level,
  input logic [4*NUM_CELLS-1:0]   cellSw,
  input logic                     periodEnd,
  input carMode_e                 activeMode
);
  localparam logic signed [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

  function automatic int cellSum(logic [4*NUM_CELLS-1:0] sw);
    int s = 0;
    for (int k = 0; k < NUM_CELLS; k++) begin
      if (sw[4*k +: 4] == SW_POS) s++;
      else if (sw[4*k +: 4] == SW_NEG) s--;
    end
    return s;
  endfunction

  // R2: the lowest reference never exceeds any carrier
  a_r2_min_ref_clear: assert property (@(posedge clk) disable iff (!rstN)
    refIn == REF_MIN |=> cmpBits == '0);

  // R8: contiguous run of ones from bit 0
  a_r8_thermometer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({1'b0, cmpBits} + {{(2*NUM_CELLS){1'b0}}, 1'b1}));

  // R5: level agrees with the sum of cell contributions
  a_r5_level_sum: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) == cellSum(cellSw));

  // R4: the arrangement changes only at a period end
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(activeMode));

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_chk
    // R6: each cell shows one of three legal codes, matching its band pair
    a_r6_cell_code: assert property (@(posedge clk) disable iff (!rstN)
      (cellSw[4*k +: 4] == SW_POS)  == cmpBits[NUM_CELLS + k] &&
      (cellSw[4*k +: 4] == SW_NEG)  == !cmpBits[NUM_CELLS - 1 - k] &&
      (cellSw[4*k +: 4] == SW_POS || cellSw[4*k +: 4] == SW_NEG || cellSw[4*k +: 4] == SW_ZERO));
  end
endmodule

bind mlpwm_modulator mlpwm_checker #(.REF_W(REF_W), .NUM_CELLS(NUM_CELLS), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refIn     (refIn),
  .cmpBits   (cmpBits),
  .level     (level),
  .cellSw    (cellSw),
  .periodEnd (strobe.periodEnd),
  .activeMode(activeMode)
);

// File: tb/tb_mlpwm_modulator.sv
module tb_mlpwm_modulator;
  import mlpwm_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [15:0]        divSet = 16'd1;
  logic [1:0]         modeSel = 2'd0;
  logic signed [9:0]  refIn = '0;
  logic [7:0]         cmpBits;
  logic signed [3:0]  level;
  logic [15:0]        cellSw;

  int checks = 0;
  int fails = 0;
  bit chkOn = 1'b0;
  bit finished = 1'b0;
  string curTag = "R7";
  int cyc = 0;

  mlpwm_modulator dut (
    .clk(clk), .rstN(rstN), .divSet(divSet), .modeSel(modeSel),
    .refIn(refIn), .cmpBits(cmpBits), .level(level), .cellSw(cellSw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected carriers from R1/R3, comparison from R2
  function automatic logic [7:0] predictBits(int r, int t, int md);
    logic [7:0] res;
    for (int i = 0; i < 8; i++) begin
      bit inv;
      int car;
      inv = (md == 1) || (md == 2 && i < 4) || (md == 3 && (i % 2) == 1);
      car = -512 + i * 128 + (inv ? 128 - t : t);
      res[i] = r > car;
    end
    return res;
  endfunction

  // R6 cell encoding
  function automatic logic [15:0] predictSw(logic [7:0] b);
    logic [15:0] sw;
    for (int k = 0; k < 4; k++) begin
      if (b[4 + k]) sw[4*k +: 4] = 4'b1001;
      else if (!b[3 - k]) sw[4*k +: 4] = 4'b0110;
      else sw[4*k +: 4] = 4'b1010;
    end
    return sw;
  endfunction

  // bench model of the phase count and mode timing (R1, R4)
  int mTri, mPre, mMode;
  bit mUp;
  logic [7:0] expBits;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTri = 0; mPre = 0; mUp = 1'b1; mMode = 0; expBits = 8'h0F;
    end else begin
      bit stp;
      expBits = predictBits(int'(refIn), mTri, mMode);
      stp = (mPre + 1) >= int'(divSet);
      if (stp) begin
        if (!mUp && mTri == 1) mMode = int'(modeSel);
        if (mUp) begin
          mTri++;
          if (mTri == 128) mUp = 1'b0;
        end else begin
          mTri--;
          if (mTri == 0) mUp = 1'b1;
        end
        mPre = 0;
      end else begin
        mPre++;
      end
    end
  end

  // continuous scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    if (chkOn) begin
      check(cmpBits === expBits, {curTag, " R2 cmpBits"}, cmpBits, expBits);
      check(int'(level) == $countones(expBits) - 4, "R5 level", level, $countones(expBits) - 4);
      check(cellSw === predictSw(expBits), "R6 cellSw", cellSw, predictSw(expBits));
    end
  end

  function automatic int pattern(int sel, int c);
    case (sel)
      0: return ((c * 5) % 1024) - 512;
      1: return ((c * 389 + 17) % 1024) - 512;
      default: return ((c * 3) % 256) - 128;
    endcase
  endfunction

  task automatic runCycles(input int n, input int sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refIn <= 10'(pattern(sel, cyc));
      cyc++;
    end
  endtask

  task automatic t_reset();
    curTag = "R7";
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(cmpBits === 8'h0F, "R7 cmpBits in reset", cmpBits, 8'h0F);
    check(level == 4'sd0, "R7 level in reset", level, 0);
    check(cellSw === 16'hAAAA, "R7 cellSw in reset", cellSw, 16'hAAAA);
    rstN = 1'b1;
    chkOn = 1'b1;
  endtask

  task automatic t_settings();
    check(DIV_SLOW == 100_000_000 / (2_000 * 256), "R9 slow divider", DIV_SLOW, 195);
    check(DIV_FAST == 39, "R9 fast divider", DIV_FAST, 39);
    check(RATIO_SLOW == 40, "R9 slow ratio", RATIO_SLOW, 40);
    check(RATIO_FAST == 200, "R9 fast ratio", RATIO_FAST, 200);
  endtask

  task automatic t_mode(input int md, input string tag);
    curTag = tag;
    @(negedge clk);
    modeSel <= 2'(md);
    runCycles(600, 0);
    runCycles(300, 1);
    check(mMode == md, {tag, " R4 mode took effect"}, mMode, md);
  endtask

  task automatic t_extremes();
    curTag = "R2";
    @(negedge clk);
    refIn <= -10'sd512;
    @(negedge clk);
    @(negedge clk);
    check(cmpBits === 8'h00, "R2 min reference bits", cmpBits, 0);
    check(level == -4'sd4, "R5 min reference level", level, -4);
    check(cellSw === 16'h6666, "R6 min reference cells", cellSw, 16'h6666);
    refIn <= 10'sd511;
    runCycles(260, 2);
  endtask

  task automatic t_midChange();
    curTag = "R4 mid";
    runCycles(70, 1);
    @(negedge clk);
    modeSel <= 2'd1;
    runCycles(40, 1);
    check(mMode == 2, "R4 old mode kept mid-period", mMode, 2);
    runCycles(300, 1);
    check(mMode == 1, "R4 new mode after boundary", mMode, 1);
  endtask

  task automatic t_boundary(input int md);
    int guard = 0;
    curTag = "R4 edge";
    @(negedge clk);
    while (!(((mPre + 1) >= int'(divSet)) && !mUp && mTri == 1) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    modeSel <= 2'(md);
    refIn <= 10'(pattern(1, cyc));
    @(negedge clk);
    check(mMode == md, "R4 same-cycle request applied", mMode, md);
    runCycles(300, 1);
  endtask

  task automatic t_divider();
    curTag = "R1 div3";
    @(negedge clk);
    divSet <= 16'd3;
    runCycles(1700, 0);
    @(negedge clk);
    divSet <= 16'd0;
    curTag = "R1 div0";
    runCycles(300, 1);
    @(negedge clk);
    divSet <= 16'd1;
  endtask

  initial begin
    t_reset();
    t_settings();
    t_mode(0, "R3 PD");
    t_mode(1, "R3 IPD");
    t_mode(2, "R3 POD");
    t_mode(3, "R3 APOD");
    t_extremes();
    t_boundary(0);
    modeSel <= 2'd2;
    runCycles(300, 0);
    t_midChange();
    t_boundary(3);
    t_divider();
    t_boundary(2);
    chkOn = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule